// File: doc/BRIEF.md
# Transmitter Operating Mode Controller

This block sequences a small radio transmitter through its power modes. It watches the enable pin, the shared data/modulation pin, the oscillator-ready flag, and the "register programmed" event and fields from the configuration loader. It then decides which analog pieces run: the synthesizer (PLL), the power amplifier, and the reference clock driver. A registered mode code reports the current state.

Synthesizer lock is not detected. It is assumed after a fixed number of reference cycles in a settling state. Once a register has been programmed, the block enters a transmit state. With on/off keying selected, the amplifier follows the data pin. With frequency keying selected, the amplifier stays on and the data pin only selects the upper tone.

A separate reprogramming path lets software load a new configuration while the oscillator keeps running. Holding the data pin high while enable is low enters that path, but only once the condition has lasted a qualified number of reference cycles.

Top module: `txModeSeq`

## Requirements
- R1: After reset the mode code is 0 (off) and the PLL, amplifier and clock-driver enables are low. While off, enable low with data high leaves the mode at 0.
- R2: From off, enable high moves to start-up 1 (code 1) on the next cycle. In start-up 1 the PLL, amplifier and clock driver are all off.
- R3: Start-up 1 waits for both a programmed register and oscillator ready. With clock-only clear it goes to start-up 2 (code 2, PLL on). With clock-only set it goes to clock-only (code 5, PLL and amplifier off).
- R4: Start-up 2 and configuration 2 each last exactly LOCK_CYCLES cycles before lock is declared. Leaving either state early restarts the count, so a later entry waits the full count again.
- R5: At lock, the block goes to transmit-RF (code 4, amplifier and PLL on) if frequency keying is selected (askSel=0), or if on/off keying is selected and data is high. With on/off keying and data low it goes to transmit-idle (code 3, PLL on, amplifier off).
- R6: In the transmit states with enable high, on/off keying makes the mode follow the data pin one cycle later (data 1 gives code 4, data 0 gives code 3). Frequency keying stays at code 4 whatever the data pin does.
- R7: In any state other than off, enable low together with data low returns the mode to off on the next cycle.
- R8: Enable low with data high, held for RESET_QUAL consecutive cycles in a state other than off, enters reprogram (code 6, PLL and amplifier off). Any shorter hold leaves the state unchanged.
- R9: From reprogram, enable high enters configuration 1 (code 7). A register programmed after that, with clock-only clear, enters configuration 2 (code 8, PLL on), which then follows the lock and transmit rules.
- R10: In clock-only, a new register-programmed event with clock-only clear moves to start-up 2.
- R11: The clock-driver enable is high exactly when clkOnSel is 1 and the mode is neither 0, 1 nor 2.
- R12: Register-programmed events that arrive while off or in reprogram are discarded. Configuration 1 waits for a fresh event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference (oscillator) clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enPin | input | 1 | Enable pin level |
| dataPin | input | 1 | Data / modulation pin level |
| oscReady | input | 1 | Oscillator amplitude good |
| regDone | input | 1 | One-cycle pulse: configuration fully loaded |
| clkOnlySel | input | 1 | Configuration field: clock-only operation |
| askSel | input | 1 | Configuration field: 1 = on/off keying, 0 = frequency keying |
| clkOnSel | input | 1 | Configuration field: clock output wanted |
| pllEn | output | 1 | Synthesizer enable |
| paEn | output | 1 | Power amplifier enable |
| clkDrvEn | output | 1 | Clock driver enable |
| modeCode | output | 4 | Current mode code (0 to 8 as above) |

## Verification
The bench builds the controller with LOCK_CYCLES=12 and RESET_QUAL=5. These values are small enough that every settling interval can be counted cycle by cycle. They also allow every short hold length from 1 to RESET_QUAL-1 to be tried before the qualifying one. With that setup, a mid-lock abort followed by a full re-wait, and multi-bit data patterns in both keying modes, each fit in a few hundred cycles.

// File: rtl/txModePkg.sv
package txModePkg;

  typedef enum logic [3:0] {
    MD_OFF     = 4'd0,
    MD_BOOT1   = 4'd1,
    MD_BOOT2   = 4'd2,
    MD_TXIDLE  = 4'd3,
    MD_TXRF    = 4'd4,
    MD_CLKONLY = 4'd5,
    MD_REPROG  = 4'd6,
    MD_CFG1    = 4'd7,
    MD_CFG2    = 4'd8
  } modeT;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic lockRun;   // settling state: advance lock timer, else clear
    logic qualRun;   // reprogram condition present: advance, else clear
    logic progClr;   // discard programmed flag
  } strobeT;

endpackage

// File: rtl/txModeDp.sv
module txModeDp
  import txModePkg::*;
#(
  parameter int LOCK_CYCLES = 1280,
  parameter int RESET_QUAL  = 130
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT stb,
  input  logic   regDone,
  output logic   lockDone,
  output logic   qualDone,
  output logic   progFlag
);

  localparam int LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam int QW = (RESET_QUAL > 1) ? $clog2(RESET_QUAL) : 1;
  localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYCLES - 1);
  localparam logic [QW-1:0] QUAL_LAST = QW'(RESET_QUAL - 1);

  logic [LW-1:0] lockCnt;
  logic [QW-1:0] qualCnt;

  assign lockDone = stb.lockRun && (lockCnt == LOCK_LAST);
  assign qualDone = stb.qualRun && (qualCnt == QUAL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lockCnt <= '0;
    else if (!stb.lockRun) lockCnt <= '0;
    else if (!lockDone)    lockCnt <= lockCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             qualCnt <= '0;
    else if (!stb.qualRun) qualCnt <= '0;
    else if (!qualDone)    qualCnt <= qualCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            progFlag <= 1'b0;
    else if (stb.progClr) progFlag <= 1'b0;
    else if (regDone)     progFlag <= 1'b1;
  end

  // R4: timer never runs past its terminal count
  a_r4_lock_bound: assert property (@(posedge clk) disable iff (!rstN)
    lockCnt <= LOCK_LAST);

  // R8: qualification timer never runs past its terminal count
  a_r8_qual_bound: assert property (@(posedge clk) disable iff (!rstN)
    qualCnt <= QUAL_LAST);

endmodule

// File: rtl/txModeCtl.sv
module txModeCtl
  import txModePkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enPin,
  input  logic   dataPin,
  input  logic   oscReady,
  input  logic   regDone,
  input  logic   clkOnlySel,
  input  logic   askSel,
  input  logic   clkOnSel,
  input  logic   lockDone,
  input  logic   qualDone,
  input  logic   progFlag,
  output strobeT stb,
  output logic   pllEn,
  output logic   paEn,
  output logic   clkDrvEn,
  output logic [3:0] modeCode
);

  modeT state, nxt;
  logic rfWanted;

  assign rfWanted = !askSel || dataPin;

  always_comb begin
    nxt = state;
    unique case (state)
      MD_OFF:              if (enPin) nxt = MD_BOOT1;
      MD_BOOT1:            if (progFlag && oscReady)
                             nxt = clkOnlySel ? MD_CLKONLY : MD_BOOT2;
      MD_BOOT2, MD_CFG2:   if (lockDone) nxt = rfWanted ? MD_TXRF : MD_TXIDLE;
      MD_TXIDLE, MD_TXRF:  nxt = rfWanted ? MD_TXRF : MD_TXIDLE;
      MD_CLKONLY:          if (regDone && !clkOnlySel) nxt = MD_BOOT2;
      MD_REPROG:           if (enPin) nxt = MD_CFG1;
      MD_CFG1:             if (progFlag) nxt = clkOnlySel ? MD_CLKONLY : MD_CFG2;
      default:             nxt = MD_OFF;
    endcase
    if (state != MD_OFF && !enPin && !dataPin) nxt = MD_OFF;
    else if (qualDone)                         nxt = MD_REPROG;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MD_OFF;
    else       state <= nxt;
  end

  always_comb begin
    stb.lockRun = (state == MD_BOOT2) || (state == MD_CFG2);
    stb.qualRun = !enPin && dataPin && (state != MD_OFF) && (state != MD_REPROG);
    stb.progClr = (state == MD_OFF) || (state == MD_REPROG);
  end

  assign pllEn    = (state == MD_BOOT2) || (state == MD_CFG2) ||
                    (state == MD_TXIDLE) || (state == MD_TXRF);
  assign paEn     = (state == MD_TXRF);
  assign clkDrvEn = clkOnSel && (state != MD_OFF) && (state != MD_BOOT1) &&
                    (state != MD_BOOT2);
  assign modeCode = state;

  a_r7_off_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state != MD_OFF && !enPin && !dataPin) |=> (state == MD_OFF));

  a_r5_no_early_tx: assert property (@(posedge clk) disable iff (!rstN)
    ((state == MD_BOOT2 || state == MD_CFG2) && !lockDone && enPin)
      |=> (state != MD_TXRF && state != MD_TXIDLE));

  a_r8_reprog_held: assert property (@(posedge clk) disable iff (!rstN)
    (state == MD_REPROG) |-> $past(!enPin && dataPin));

  a_r6_fsk_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((state == MD_TXRF || state == MD_TXIDLE) && !askSel && enPin)
      |=> (state == MD_TXRF));

  a_r6_ask_gate: assert property (@(posedge clk) disable iff (!rstN)
    ((state == MD_TXRF || state == MD_TXIDLE) && askSel && enPin)
      |=> (paEn == $past(dataPin)));

endmodule

// File: rtl/txModeSeq.sv
module txModeSeq
  import txModePkg::*;
#(
  parameter int LOCK_CYCLES = 1280,
  parameter int RESET_QUAL  = 130
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enPin,
  input  logic       dataPin,
  input  logic       oscReady,
  input  logic       regDone,
  input  logic       clkOnlySel,
  input  logic       askSel,
  input  logic       clkOnSel,
  output logic       pllEn,
  output logic       paEn,
  output logic       clkDrvEn,
  output logic [3:0] modeCode
);

  strobeT stb;
  logic   lockDone, qualDone, progFlag;

  txModeCtl uCtl (
    .clk(clk), .rstN(rstN), .enPin(enPin), .dataPin(dataPin),
    .oscReady(oscReady), .regDone(regDone), .clkOnlySel(clkOnlySel),
    .askSel(askSel), .clkOnSel(clkOnSel), .lockDone(lockDone),
    .qualDone(qualDone), .progFlag(progFlag), .stb(stb), .pllEn(pllEn),
    .paEn(paEn), .clkDrvEn(clkDrvEn), .modeCode(modeCode)
  );

  txModeDp #(.LOCK_CYCLES(LOCK_CYCLES), .RESET_QUAL(RESET_QUAL)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .regDone(regDone),
    .lockDone(lockDone), .qualDone(qualDone), .progFlag(progFlag)
  );

endmodule

// File: tb/sim_txModeSeq.sv
module sim_txModeSeq;

  localparam int LOCK = 12;
  localparam int QUAL = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0, dat = 1'b0, osc = 1'b0, rd = 1'b0;
  logic cOnly = 1'b0, ask = 1'b0, cOn = 1'b1;
  logic pllEn, paEn, clkDrvEn;
  logic [3:0] modeCode;
  int nRun = 0, nFail = 0;

  always #5 clk = ~clk;

  txModeSeq #(.LOCK_CYCLES(LOCK), .RESET_QUAL(QUAL)) u0 (
    .clk(clk), .rstN(rstN), .enPin(en), .dataPin(dat), .oscReady(osc),
    .regDone(rd), .clkOnlySel(cOnly), .askSel(ask), .clkOnSel(cOn),
    .pllEn(pllEn), .paEn(paEn), .clkDrvEn(clkDrvEn), .modeCode(modeCode)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseReg();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  task automatic waitMode(input int code, output int got);
    int k = 0;
    while (modeCode != code && k < 40) begin k++; step(1); end
    got = modeCode;
  endtask

  task automatic dwell(input int code, output int n);
    n = 0;
    while (modeCode == code && n < 200) begin n++; step(1); end
  endtask

  initial begin
    int got, n;
    int pat;
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 reset mode", modeCode, 0);
    chk("R1 reset enables", {pllEn, paEn, clkDrvEn}, 0);
    dat = 1'b1; step(QUAL + 4);
    chk("R1 R8 off ignores data high", modeCode, 0);
    dat = 1'b0; en = 1'b1; step(1);
    chk("R2 boot1 mode", modeCode, 1);
    chk("R2 boot1 enables", {pllEn, paEn, clkDrvEn}, 0);
    pulseReg(); step(3);
    chk("R3 waits for oscillator", modeCode, 1);
    osc = 1'b1; waitMode(2, got);
    chk("R3 boot2 reached", got, 2);
    chk("R3 boot2 pll on", pllEn, 1);
    chk("R11 no clock in boot2", clkDrvEn, 0);
    dwell(2, n);
    chk("R4 lock interval", n, LOCK);
    chk("R5 fsk tx mode", modeCode, 4);
    chk("R5 fsk pa on", paEn, 1);
    for (int i = 0; i < 6; i++) begin
      dat = i[0]; step(1);
      chk("R6 fsk ignores data", modeCode, 4);
    end
    en = 1'b0; dat = 1'b0; step(1);
    chk("R7 tx to off", modeCode, 0);
    chk("R7 off enables", {pllEn, paEn}, 0);

    // mid-lock abort then full re-wait, on/off keying
    ask = 1'b1; en = 1'b1; step(1);
    pulseReg(); waitMode(2, got);
    step(3);
    en = 1'b0; step(1);
    chk("R7 boot2 abort to off", modeCode, 0);
    en = 1'b1; step(1);
    pulseReg(); waitMode(2, got);
    dwell(2, n);
    chk("R4 full re-wait after abort", n, LOCK);
    chk("R5 ask data low idle", modeCode, 3);
    chk("R5 ask idle pa off", paEn, 0);
    chk("R5 ask idle pll on", pllEn, 1);
    pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) begin
      dat = pat[i]; step(1);
      chk("R6 ask follows data", modeCode, pat[i] ? 4 : 3);
      chk("R6 ask pa gate", paEn, pat[i]);
    end
    chk("R11 clock on in tx", clkDrvEn, 1);
    cOn = 1'b0; #1;
    chk("R11 clock off when unselected", clkDrvEn, 0);
    cOn = 1'b1;

    // qualification sweep for reprogram entry
    dat = 1'b1; step(1);
    for (int len = 1; len < QUAL; len++) begin
      en = 1'b0; step(len);
      chk("R8 short hold ignored", modeCode, 4);
      en = 1'b1; step(1);
    end
    en = 1'b0; step(QUAL);
    chk("R8 reprog entered", modeCode, 6);
    chk("R8 reprog pll pa off", {pllEn, paEn}, 0);
    chk("R11 clock on in reprog", clkDrvEn, 1);
    pulseReg(); step(1);
    en = 1'b1; step(1);
    chk("R9 cfg1 entered", modeCode, 7);
    step(3);
    chk("R12 stale event discarded", modeCode, 7);
    cOnly = 1'b0; pulseReg(); waitMode(8, got);
    chk("R9 cfg2 reached", got, 8);
    chk("R9 cfg2 pll on", pllEn, 1);
    dwell(8, n);
    chk("R9 R4 cfg2 lock interval", n, LOCK);
    chk("R9 tx after cfg2", modeCode, 4);

    // clock-only path
    en = 1'b0; dat = 1'b0; step(1);
    en = 1'b1; cOnly = 1'b1; step(1);
    pulseReg(); waitMode(5, got);
    chk("R3 clock-only reached", got, 5);
    chk("R3 clock-only pll pa off", {pllEn, paEn}, 0);
    chk("R11 clock on in clock-only", clkDrvEn, 1);
    cOnly = 1'b0; pulseReg();
    chk("R10 clock-only to boot2", modeCode, 2);

    // reprogram then leave to off
    en = 1'b0; dat = 1'b1; step(QUAL);
    chk("R8 reprog from boot2", modeCode, 6);
    dat = 1'b0; step(1);
    chk("R7 reprog to off", modeCode, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule